// File: doc/BRIEF.md
# Control Word Sequencer for a Multi-Cell Noise Source

This block programs the control register of a noise-generator unit that has several oscillator cells sharing one physical register. On request it builds an ordered list of control words (one per cell, then a final word) and writes them in turn into that register. Each per-cell word gives one cell its own oscillator setting and enables only that cell. The last word turns all cells on together for normal operation. A self-test variant of the list is also available: the per-cell words carry no enables and the last word sets a fixed self-test wait.

Each register access returns a response. An access can succeed, report busy, report would-block with a tick count, or fail. A busy response is retried after a fixed delay and a would-block response after the returned tick count. Each kind has its own retry limit. After the last write the block reads the register back until the read succeeds, which confirms the write took effect. It then gives a one-cycle completion pulse with a status code.

Top module: `ctlseq_top`

## Requirements
- R1: One request gives NCELL+1 write operations (op_write=1), for word index 0, 1, …, NCELL in that order. Then it gives read-back operations (op_write=0, data 0) until one is answered OK. A successful run ends with a one-cycle `done` and status 0. Response codes are 0 ok, 1 busy, 2 would-block and 3 fault.
- R2: Word layout with default parameters: bit 0 is the conditioning mode, bits 3:1 are the cell enables (cell c at bit 1+c), bits 5:4 are the oscillator setting, bits 7:6 are the analog select and bits 23:8 are the wait count. In normal mode, word c (c<NCELL) has mode=1, enable bit of cell c only, oscillator field = that cell's `cell_osc` slice, analog select = 2 and wait = `cfg_wait`.
- R3: In normal mode the final word has mode=1, all cell enables set, oscillator field 0, analog select 2 and wait = `cfg_wait`.
- R4: In self-test mode the per-cell words contain only analog select = 2. The final word has analog select 2, mode=1 and wait = ST_TICKS-2, with no enables.
- R5: After a busy response the same operation is reissued, with the new op appearing BUSY_DELAY+3 cycles after the response cycle. The BUSY_LIMIT-th busy response of a request ends it with status 1 and no further operations.
- R6: After a would-block response with tick count T the same operation is reissued T+3 cycles after the response cycle. The BLOCK_LIMIT-th would-block response ends the request with status 2.
- R7: A fault response ends the request at once with status 3.
- R8: Read-back operations follow the same busy and would-block retry rules as the writes.
- R9: The busy and would-block retry counts restart from zero at every new request.
- R10: `seq_busy` is high from the cycle after an accepted request until `done`. `done` is a single-cycle pulse with `seq_busy` low. A request while busy is ignored.
- R11: Every operation is a single-cycle `op_valid` pulse issued only while busy. After an OK response the next op follows 2 cycles after the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a configuration sequence |
| req_selftest | input | 1 | Use the self-test word list (sampled with req) |
| cfg_wait | input | WAIT_W | Wait count for normal-mode words |
| cell_osc | input | NCELL*OSC_W | Oscillator setting per cell, cell c at [c*OSC_W +: OSC_W] |
| op_valid | output | 1 | Register operation pulse |
| op_write | output | 1 | 1 = write, 0 = read-back |
| op_wdata | output | WORD_W | Control word for writes, 0 for read-back |
| rsp_valid | input | 1 | Response to the outstanding operation |
| rsp_code | input | 2 | 0 ok, 1 busy, 2 would-block, 3 fault |
| rsp_ticks | input | TICK_W | Wait ticks returned with a would-block |
| seq_busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 busy limit, 2 would-block limit, 3 fault |

## Verification
Two normal-mode runs use distinct oscillator and wait values, so a swapped cell slice or a misplaced field shows as a wrong word. A self-test run separates the two word lists. Busy and would-block responses are placed on writes and on the read-back, with tick counts of 0 and nonzero. Some runs stop just short of a limit and others reach it, which separates an off-by-one limit from a correct one and checks the reissue gap. Two back-to-back requests share a busy history, which shows whether the counts restart per request. A stray request mid-run must add no operations.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DELAY = 2'd3
  } seq_state_t;

  localparam logic [1:0] RSP_OK    = 2'd0;
  localparam logic [1:0] RSP_BUSY  = 2'd1;
  localparam logic [1:0] RSP_BLOCK = 2'd2;
  localparam logic [1:0] RSP_FAULT = 2'd3;

  localparam logic [1:0] STS_OK       = 2'd0;
  localparam logic [1:0] STS_BUSY_TO  = 2'd1;
  localparam logic [1:0] STS_BLOCK_TO = 2'd2;
  localparam logic [1:0] STS_FAULT    = 2'd3;

  localparam logic [1:0] ASEL_VALUE = 2'd2;
endpackage

// File: rtl/ctlseq_wordgen.sv
module ctlseq_wordgen #(
  parameter int NCELL    = 3,
  parameter int OSC_W    = 2,
  parameter int WAIT_W   = 16,
  parameter int ST_TICKS = 14,
  parameter int IDX_W    = $clog2(NCELL + 1),
  parameter int WORD_W   = 1 + NCELL + OSC_W + 2 + WAIT_W
) (
  input  logic                   selftest,
  input  logic [WAIT_W-1:0]      wait_cnt,
  input  logic [NCELL*OSC_W-1:0] osc_vec,
  input  logic [IDX_W-1:0]       idx,
  output logic [WORD_W-1:0]      word
);
  import ctlseq_pkg::*;

  localparam int EN_LSB   = 1;
  localparam int OSC_LSB  = EN_LSB + NCELL;
  localparam int ASEL_LSB = OSC_LSB + OSC_W;
  localparam int WAIT_LSB = ASEL_LSB + 2;

  logic [WORD_W-1:0] base_norm;
  logic [WORD_W-1:0] base_st;
  logic [WORD_W-1:0] cell_word [NCELL];
  logic [WORD_W-1:0] final_norm;
  logic [WORD_W-1:0] final_st;

  always_comb begin
    base_norm = '0;
    base_norm[0] = 1'b1;
    base_norm[ASEL_LSB +: 2] = ASEL_VALUE;
    base_norm[WAIT_LSB +: WAIT_W] = wait_cnt;
    base_st = '0;
    base_st[ASEL_LSB +: 2] = ASEL_VALUE;
    final_norm = base_norm;
    final_norm[EN_LSB +: NCELL] = '1;
    final_st = base_st;
    final_st[0] = 1'b1;
    final_st[WAIT_LSB +: WAIT_W] = WAIT_W'(ST_TICKS - 2);
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    always_comb begin
      cell_word[c] = base_norm;
      cell_word[c][EN_LSB + c] = 1'b1;
      cell_word[c][OSC_LSB +: OSC_W] = osc_vec[c*OSC_W +: OSC_W];
    end
  end

  always_comb begin
    if (idx == IDX_W'(NCELL)) begin
      word = selftest ? final_st : final_norm;
    end else begin
      word = base_st;
      for (int c = 0; c < NCELL; c++) begin
        if (!selftest && idx == IDX_W'(c)) word = cell_word[c];
      end
    end
  end
endmodule

// File: rtl/ctlseq_retry.sv
module ctlseq_retry #(
  parameter int BUSY_LIMIT  = 4,
  parameter int BLOCK_LIMIT = 3,
  parameter int TICK_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              busy_hit,
  input  logic              block_hit,
  input  logic              load,
  input  logic [TICK_W-1:0] load_val,
  input  logic              tick_en,
  output logic              busy_last,
  output logic              block_last,
  output logic              timer_zero
);
  localparam int BCW = $clog2(BUSY_LIMIT + 1);
  localparam int KCW = $clog2(BLOCK_LIMIT + 1);

  logic [BCW-1:0]    busy_cnt;
  logic [KCW-1:0]    block_cnt;
  logic [TICK_W-1:0] timer;

  assign busy_last  = (busy_cnt >= BCW'(BUSY_LIMIT - 1));
  assign block_last = (block_cnt >= KCW'(BLOCK_LIMIT - 1));
  assign timer_zero = (timer == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_cnt  <= '0;
      block_cnt <= '0;
    end else begin
      if (busy_hit && !busy_last)   busy_cnt  <= busy_cnt + 1'b1;
      if (block_hit && !block_last) block_cnt <= block_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else if (load) begin
      timer <= load_val;
    end else if (tick_en && !timer_zero) begin
      timer <= timer - 1'b1;
    end
  end
endmodule

// File: rtl/ctlseq_top.sv
module ctlseq_top #(
  parameter int NCELL       = 3,
  parameter int OSC_W       = 2,
  parameter int WAIT_W      = 16,
  parameter int TICK_W      = 8,
  parameter int BUSY_LIMIT  = 4,
  parameter int BLOCK_LIMIT = 3,
  parameter int BUSY_DELAY  = 3,
  parameter int ST_TICKS    = 14,
  localparam int WORD_W     = 1 + NCELL + OSC_W + 2 + WAIT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req,
  input  logic                   req_selftest,
  input  logic [WAIT_W-1:0]      cfg_wait,
  input  logic [NCELL*OSC_W-1:0] cell_osc,
  output logic                   op_valid,
  output logic                   op_write,
  output logic [WORD_W-1:0]      op_wdata,
  input  logic                   rsp_valid,
  input  logic [1:0]             rsp_code,
  input  logic [TICK_W-1:0]      rsp_ticks,
  output logic                   seq_busy,
  output logic                   done,
  output logic [1:0]             status
);
  import ctlseq_pkg::*;

  localparam int IDX_W = $clog2(NCELL + 1);

  seq_state_t             state;
  logic [IDX_W-1:0]       idx;
  logic                   settle;
  logic                   sel_st;
  logic [WAIT_W-1:0]      wait_q;
  logic [NCELL*OSC_W-1:0] osc_q;
  logic [WORD_W-1:0]      word;

  logic start, got, busy_hit, block_hit, busy_last, block_last, timer_zero;
  logic [TICK_W-1:0] load_val;

  assign start     = (state == S_IDLE) && req;
  assign got       = (state == S_WAIT) && rsp_valid;
  assign busy_hit  = got && (rsp_code == RSP_BUSY);
  assign block_hit = got && (rsp_code == RSP_BLOCK);
  assign load_val  = busy_hit ? TICK_W'(BUSY_DELAY) : rsp_ticks;

  ctlseq_wordgen #(
    .NCELL(NCELL), .OSC_W(OSC_W), .WAIT_W(WAIT_W), .ST_TICKS(ST_TICKS),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_wordgen (
    .selftest(sel_st), .wait_cnt(wait_q), .osc_vec(osc_q), .idx(idx), .word(word)
  );

  ctlseq_retry #(
    .BUSY_LIMIT(BUSY_LIMIT), .BLOCK_LIMIT(BLOCK_LIMIT), .TICK_W(TICK_W)
  ) u_retry (
    .clk(clk), .rst(rst), .clr(start),
    .busy_hit(busy_hit), .block_hit(block_hit),
    .load(busy_hit || block_hit), .load_val(load_val),
    .tick_en(state == S_DELAY),
    .busy_last(busy_last), .block_last(block_last), .timer_zero(timer_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      settle   <= 1'b0;
      sel_st   <= 1'b0;
      wait_q   <= '0;
      osc_q    <= '0;
      op_valid <= 1'b0;
      op_write <= 1'b0;
      op_wdata <= '0;
      seq_busy <= 1'b0;
      done     <= 1'b0;
      status   <= STS_OK;
    end else begin
      op_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req) begin
            idx      <= '0;
            settle   <= 1'b0;
            sel_st   <= req_selftest;
            wait_q   <= cfg_wait;
            osc_q    <= cell_osc;
            seq_busy <= 1'b1;
            state    <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          op_valid <= 1'b1;
          op_write <= !settle;
          op_wdata <= settle ? '0 : word;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_valid) begin
            unique case (rsp_code)
              RSP_OK: begin
                if (settle) begin
                  status   <= STS_OK;
                  done     <= 1'b1;
                  seq_busy <= 1'b0;
                  state    <= S_IDLE;
                end else begin
                  if (idx == IDX_W'(NCELL)) settle <= 1'b1;
                  else                      idx    <= idx + 1'b1;
                  state <= S_ISSUE;
                end
              end
              RSP_BUSY: begin
                if (busy_last) begin
                  status   <= STS_BUSY_TO;
                  done     <= 1'b1;
                  seq_busy <= 1'b0;
                  state    <= S_IDLE;
                end else begin
                  state <= S_DELAY;
                end
              end
              RSP_BLOCK: begin
                if (block_last) begin
                  status   <= STS_BLOCK_TO;
                  done     <= 1'b1;
                  seq_busy <= 1'b0;
                  state    <= S_IDLE;
                end else begin
                  state <= S_DELAY;
                end
              end
              default: begin
                status   <= STS_FAULT;
                done     <= 1'b1;
                seq_busy <= 1'b0;
                state    <= S_IDLE;
              end
            endcase
          end
        end
        S_DELAY: begin
          if (timer_zero) state <= S_ISSUE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctlseq_chk.sv
module ctlseq_chk #(
  parameter int WORD_W   = 24,
  parameter int ASEL_LSB = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              op_valid,
  input logic              op_write,
  input logic [WORD_W-1:0] op_wdata,
  input logic              seq_busy,
  input logic              done
);
  p_op_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  p_op_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> seq_busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !seq_busy);

  p_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (req && !seq_busy && !done) |=> seq_busy);

  p_asel_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_write) |-> (op_wdata[ASEL_LSB +: 2] == 2'd2));

  p_readback_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_write) |-> (op_wdata == '0));
endmodule

bind ctlseq_top ctlseq_chk #(
  .WORD_W(WORD_W), .ASEL_LSB(1 + NCELL + OSC_W)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .op_valid(op_valid), .op_write(op_write),
  .op_wdata(op_wdata), .seq_busy(seq_busy), .done(done)
);

// File: tb/tb_ctlseq_top.sv
module tb_ctlseq_top;
  localparam int NCELL = 3, OSC_W = 2, WAIT_W = 16, TICK_W = 8;
  localparam int BUSY_LIMIT = 4, BLOCK_LIMIT = 3, BUSY_DELAY = 3, ST_TICKS = 14;
  localparam int WORD_W = 1 + NCELL + OSC_W + 2 + WAIT_W;

  logic clk = 0, rst = 1;
  logic req = 0, req_selftest = 0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic [NCELL*OSC_W-1:0] cell_osc = '0;
  logic op_valid, op_write, seq_busy, done;
  logic [WORD_W-1:0] op_wdata;
  logic rsp_valid = 0;
  logic [1:0] rsp_code = 0;
  logic [TICK_W-1:0] rsp_ticks = 0;
  logic [1:0] status;

  always #2 clk = ~clk;

  ctlseq_top #(
    .NCELL(NCELL), .OSC_W(OSC_W), .WAIT_W(WAIT_W), .TICK_W(TICK_W),
    .BUSY_LIMIT(BUSY_LIMIT), .BLOCK_LIMIT(BLOCK_LIMIT),
    .BUSY_DELAY(BUSY_DELAY), .ST_TICKS(ST_TICKS)
  ) dut (.*);

  typedef struct { logic wr; logic [WORD_W-1:0] data; int gap; string tag; } exp_t;
  typedef struct { logic [1:0] code; logic [TICK_W-1:0] ticks; } rsp_t;

  exp_t exp_q[$];
  rsp_t rsp_q[$];
  int nchk = 0, nfail = 0, gap = 0;
  bit finished = 0;

  function automatic logic [WORD_W-1:0] mkword(bit st, logic [WAIT_W-1:0] w,
                                               logic [5:0] osc, int i);
    logic [WORD_W-1:0] r;
    r = '0;
    r[7:6] = 2'd2;
    if (!st) begin
      r[0] = 1'b1;
      r[23:8] = w;
      if (i == 3) r[3:1] = 3'b111;
      else begin r[1+i] = 1'b1; r[5:4] = osc[2*i +: 2]; end
    end else if (i == 3) begin
      r[0] = 1'b1;
      r[23:8] = 16'(ST_TICKS - 2);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ex(logic wr, logic [WORD_W-1:0] d, int g, string tag);
    exp_t e;
    e.wr = wr; e.data = d; e.gap = g; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rs(logic [1:0] c, int t);
    rsp_t r;
    r.code = c; r.ticks = TICK_W'(t);
    rsp_q.push_back(r);
  endtask

  // monitor: pops expected operations and answers from the response script
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) rsp_valid = 0;
      gap++;
      if (op_valid && !rst) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected op", op_wdata, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(op_write == e.wr, e.tag, "op_write", op_write, e.wr);
          chk(op_wdata == e.data, e.tag, "op_wdata", op_wdata, e.data);
          if (e.gap >= 0) chk(gap == e.gap, e.tag, "op gap", gap, e.gap);
        end
        if (rsp_q.size() > 0) begin
          rsp_t r;
          r = rsp_q.pop_front();
          rsp_code = r.code; rsp_ticks = r.ticks; rsp_valid = 1;
          gap = 0;
        end
      end
    end
  end

  task automatic run(bit st, logic [WAIT_W-1:0] w, logic [5:0] osc,
                     logic [1:0] exp_sts, bit mid_req, string tag);
    int n;
    @(negedge clk);
    req = 1; req_selftest = st; cfg_wait = w; cell_osc = osc;
    @(negedge clk);
    req = 0; req_selftest = 0;
    chk(seq_busy == 1, "R10", "busy after req", seq_busy, 1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (mid_req && n == 6) begin req = 1; req_selftest = ~st; cfg_wait = ~w; end
      if (mid_req && n == 7) req = 0;
    end
    chk(done == 1, tag, "done seen", done, 1);
    chk(seq_busy == 0, "R10", "busy low at done", seq_busy, 0);
    chk(status == exp_sts, tag, "status", status, exp_sts);
    @(negedge clk);
    chk(done == 0, "R10", "done pulse width", done, 0);
    chk(exp_q.size() == 0, tag, "ops left unissued", exp_q.size(), 0);
    exp_q.delete(); rsp_q.delete();
  endtask

  task automatic all_ok(bit st, logic [WAIT_W-1:0] w, logic [5:0] osc, string tag);
    for (int i = 0; i < 4; i++) begin
      ex(1, mkword(st, w, osc, i), (i == 0) ? -1 : 2, tag);
      rs(0, 0);
    end
    ex(0, '0, 2, "R1");
    rs(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(op_valid == 0, "R11", "reset op_valid", op_valid, 0);
    chk(done == 0, "R10", "reset done", done, 0);
    chk(seq_busy == 0, "R10", "reset busy", seq_busy, 0);
    chk(status == 0, "R1", "reset status", status, 0);

    // R1 R2 R3: normal list, cells 1/2/3
    all_ok(0, 16'h0040, 6'b11_10_01, "R2");
    run(0, 16'h0040, 6'b11_10_01, 2'd0, 0, "R1");
    // R2 R3: different pattern
    all_ok(0, 16'hFFFF, 6'b10_00_11, "R3");
    run(0, 16'hFFFF, 6'b10_00_11, 2'd0, 0, "R3");
    // R4: self-test list
    all_ok(1, 16'h1234, 6'b11_11_11, "R4");
    run(1, 16'h1234, 6'b11_11_11, 2'd0, 0, "R4");

    // R5: two busy on word 1 then ok
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 0), -1, "R5"); rs(0, 0);
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 1), 2, "R5"); rs(1, 0);
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 1), BUSY_DELAY + 3, "R5"); rs(1, 0);
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 1), BUSY_DELAY + 3, "R5"); rs(0, 0);
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 2), 2, "R11"); rs(0, 0);
    ex(1, mkword(0, 16'h0007, 6'b01_10_11, 3), 2, "R5"); rs(0, 0);
    ex(0, '0, 2, "R5"); rs(0, 0);
    run(0, 16'h0007, 6'b01_10_11, 2'd0, 0, "R5");

    // R5: busy limit reached
    for (int i = 0; i < BUSY_LIMIT; i++) begin
      ex(1, mkword(0, 16'h0001, 6'b00_00_01, 0), (i == 0) ? -1 : BUSY_DELAY + 3, "R5");
      rs(1, 0);
    end
    run(0, 16'h0001, 6'b00_00_01, 2'd1, 0, "R5");

    // R6: would-block with ticks 5 and 0, then ok
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 0), -1, "R6"); rs(0, 0);
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 1), 2, "R6"); rs(2, 5);
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 1), 8, "R6"); rs(2, 0);
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 1), 3, "R6"); rs(0, 0);
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 2), 2, "R6"); rs(0, 0);
    ex(1, mkword(0, 16'h0020, 6'b01_01_01, 3), 2, "R6"); rs(0, 0);
    ex(0, '0, 2, "R6"); rs(0, 0);
    run(0, 16'h0020, 6'b01_01_01, 2'd0, 0, "R6");

    // R6: would-block limit reached
    ex(1, mkword(0, 16'h0002, 6'b00_00_10, 0), -1, "R6"); rs(2, 1);
    ex(1, mkword(0, 16'h0002, 6'b00_00_10, 0), 4, "R6"); rs(2, 1);
    ex(1, mkword(0, 16'h0002, 6'b00_00_10, 0), 4, "R6"); rs(2, 1);
    run(0, 16'h0002, 6'b00_00_10, 2'd2, 0, "R6");

    // R7: fault on word 2
    ex(1, mkword(0, 16'h0003, 6'b11_00_11, 0), -1, "R7"); rs(0, 0);
    ex(1, mkword(0, 16'h0003, 6'b11_00_11, 1), 2, "R7"); rs(0, 0);
    ex(1, mkword(0, 16'h0003, 6'b11_00_11, 2), 2, "R7"); rs(3, 0);
    run(0, 16'h0003, 6'b11_00_11, 2'd3, 0, "R7");

    // R8: read-back retried on busy and would-block
    for (int i = 0; i < 4; i++) begin
      ex(1, mkword(0, 16'h0100, 6'b10_01_00, i), (i == 0) ? -1 : 2, "R8");
      rs(0, 0);
    end
    ex(0, '0, 2, "R8"); rs(1, 0);
    ex(0, '0, BUSY_DELAY + 3, "R8"); rs(2, 2);
    ex(0, '0, 5, "R8"); rs(0, 0);
    run(0, 16'h0100, 6'b10_01_00, 2'd0, 0, "R8");

    // R9: three busy then fault, then three busy then success
    for (int i = 0; i < 4; i++) begin
      ex(1, mkword(0, 16'h0011, 6'b01_11_10, 0), (i == 0) ? -1 : BUSY_DELAY + 3, "R9");
      rs((i == 3) ? 2'd3 : 2'd1, 0);
    end
    run(0, 16'h0011, 6'b01_11_10, 2'd3, 0, "R9");
    for (int i = 0; i < 3; i++) begin
      ex(1, mkword(0, 16'h0011, 6'b01_11_10, 0), (i == 0) ? -1 : BUSY_DELAY + 3, "R9");
      rs(1, 0);
    end
    ex(1, mkword(0, 16'h0011, 6'b01_11_10, 0), BUSY_DELAY + 3, "R9"); rs(0, 0);
    for (int i = 1; i < 4; i++) begin
      ex(1, mkword(0, 16'h0011, 6'b01_11_10, i), 2, "R9"); rs(0, 0);
    end
    ex(0, '0, 2, "R9"); rs(0, 0);
    run(0, 16'h0011, 6'b01_11_10, 2'd0, 0, "R9");

    // R10: a request while busy adds nothing and changes no word
    all_ok(0, 16'h0ABC, 6'b00_11_01, "R10");
    run(0, 16'h0ABC, 6'b00_11_01, 2'd0, 1, "R10");
    repeat (10) @(negedge clk);
    chk(seq_busy == 0, "R10", "idle after ignored req", seq_busy, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule